// File: doc/BRIEF.md
# Leading/Trailing Zero Counter

This block counts a run of zero bits in a 64-bit operand, either from the most significant end downward or from bit 0 upward. A second control restricts the count to the low 32-bit word, so that one datapath covers four operations: leading or trailing count, each on a doubleword or on a word. The count comes back zero-extended on a 64-bit result bus, ready to be written to a register.

The logic is purely combinational, with no clock or reset. A result is valid while its operand and mode inputs are held. The block has no data stream with flow control. Operand and result are plain buses, so there is no valid/ready pair and no back-pressure rule. The caller registers the result wherever its pipeline needs it.

Internally the examined field is first aligned to the top of a 64-bit working vector. For trailing counts the field is also bit-reversed. In word mode a single marker bit is placed just below the field. A grouped priority encoder then finds the first set bit. Because of the marker, an all-zero word stops at 32 and an all-zero doubleword runs to 64, so no separate zero-detect path is needed.

Top module: `zero_run_counter`

## Requirements
- R1: With `trail_i`=0 and `word_i`=0, if the highest set bit of `operand_i` is at position p, `count_o` equals 63-p.
- R2: With `trail_i`=0 and `word_i`=1, if the highest set bit within `operand_i[31:0]` is at position p, `count_o` equals 31-p. Bits 63..32 have no effect on the result.
- R3: With `trail_i`=1 and `word_i`=0, `count_o` equals the index of the lowest set bit of `operand_i`.
- R4: With `trail_i`=1 and `word_i`=1, `count_o` equals the index of the lowest set bit within `operand_i[31:0]`. Bits 63..32 have no effect on the result.
- R5: With `word_i`=0 and `operand_i` all zero, `count_o` equals 64 (0x40) for either value of `trail_i`.
- R6: With `word_i`=1 and `operand_i[31:0]` all zero, `count_o` equals 32 (0x20) for either value of `trail_i`, whatever bits 63..32 hold.
- R7: `count_o[63:7]` is always zero. The count never exceeds 32 in word mode or 64 in doubleword mode.
- R8: `count_o` follows a change on any input within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 64 | Value whose zero run is counted |
| trail_i | input | 1 | 0: count from bit 63 downward; 1: count from bit 0 upward |
| word_i | input | 1 | 1: examine only bits 31..0; 0: examine all 64 bits |
| count_o | output | 64 | Zero-extended count of consecutive zero bits |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages between input and output. The bench therefore drives the operand and the mode just after a rising edge and samples `count_o` at the following falling edge, half a period later. One extra check changes the inputs in the middle of a cycle and samples one nanosecond later, which shows that no hidden register delays the count. Expected counts come from a bench loop that scans the examined field bit by bit.

// File: rtl/zrc_pkg.sv
package zrc_pkg;

  typedef enum logic {
    SCAN_FROM_TOP    = 1'b0,
    SCAN_FROM_BOTTOM = 1'b1
  } zrc_dir_e;

  typedef enum logic {
    SPAN_DOUBLE = 1'b0,
    SPAN_LOW    = 1'b1
  } zrc_span_e;

endpackage

// File: rtl/zrc_field_prep.sv
module zrc_field_prep
  import zrc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input  logic [DATA_W-1:0] operand_i,
  input  zrc_dir_e          dir_i,
  input  zrc_span_e         span_i,
  output logic [DATA_W-1:0] field_o
);
  localparam int PAD_W = DATA_W - HALF_W;

  logic [DATA_W-1:0] rev_full;
  logic [HALF_W-1:0] rev_half;
  logic [PAD_W-1:0]  marker;

  assign marker = {1'b1, {(PAD_W-1){1'b0}}};

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_full
    assign rev_full[i] = operand_i[DATA_W-1-i];
  end

  for (genvar j = 0; j < HALF_W; j++) begin : g_rev_half
    assign rev_half[j] = operand_i[HALF_W-1-j];
  end

  // Left-align the examined field; in word mode a marker bit stops the scan at HALF_W.
  always_comb begin
    unique case ({dir_i, span_i})
      {SCAN_FROM_TOP,    SPAN_DOUBLE}: field_o = operand_i;
      {SCAN_FROM_TOP,    SPAN_LOW}:    field_o = {operand_i[HALF_W-1:0], marker};
      {SCAN_FROM_BOTTOM, SPAN_DOUBLE}: field_o = rev_full;
      default:                         field_o = {rev_half, marker};
    endcase
  end

endmodule

// File: rtl/zrc_group_enc.sv
module zrc_group_enc #(
  parameter int GROUP_W = 8,
  localparam int LZ_W   = $clog2(GROUP_W)
) (
  input  logic [GROUP_W-1:0] bits_i,
  output logic               nz_o,
  output logic [LZ_W-1:0]    lz_o
);
  logic hit;

  always_comb begin
    nz_o = |bits_i;
    lz_o = '0;
    hit  = 1'b0;
    for (int i = GROUP_W - 1; i >= 0; i--) begin
      if (!hit && bits_i[i]) begin
        lz_o = LZ_W'(GROUP_W - 1 - i);
        hit  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/zrc_group_merge.sv
module zrc_group_merge #(
  parameter int DATA_W  = 64,
  parameter int GROUP_W = 8,
  localparam int NGRP   = DATA_W / GROUP_W,
  localparam int LZ_W   = $clog2(GROUP_W),
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [NGRP-1:0]      nz_i,
  input  logic [NGRP*LZ_W-1:0] lz_i,
  output logic [CNT_W-1:0]     cnt_o
);
  logic hit;

  // Group 0 holds the most significant bits of the aligned field.
  always_comb begin
    cnt_o = CNT_W'(DATA_W);
    hit   = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      if (!hit && nz_i[g]) begin
        cnt_o = CNT_W'(g * GROUP_W) + CNT_W'(lz_i[g*LZ_W +: LZ_W]);
        hit   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/zero_run_counter.sv
module zero_run_counter
  import zrc_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int HALF_W  = 32,
  parameter int GROUP_W = 8
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              trail_i,
  input  logic              word_i,
  output logic [DATA_W-1:0] count_o
);
  localparam int NGRP  = DATA_W / GROUP_W;
  localparam int LZ_W  = $clog2(GROUP_W);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0]    field;
  logic [NGRP-1:0]      grp_nz;
  logic [NGRP*LZ_W-1:0] grp_lz;
  logic [CNT_W-1:0]     cnt;

  zrc_field_prep #(.DATA_W(DATA_W), .HALF_W(HALF_W)) prep_i (
    .operand_i (operand_i),
    .dir_i     (zrc_dir_e'(trail_i)),
    .span_i    (zrc_span_e'(word_i)),
    .field_o   (field)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    zrc_group_enc #(.GROUP_W(GROUP_W)) enc_i (
      .bits_i (field[DATA_W-1-g*GROUP_W -: GROUP_W]),
      .nz_o   (grp_nz[g]),
      .lz_o   (grp_lz[g*LZ_W +: LZ_W])
    );
  end

  zrc_group_merge #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) merge_i (
    .nz_i  (grp_nz),
    .lz_i  (grp_lz),
    .cnt_o (cnt)
  );

  assign count_o = {{(DATA_W-CNT_W){1'b0}}, cnt};

endmodule

// File: rtl/zrc_checker.sv
module zrc_checker #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input logic [DATA_W-1:0] operand_i,
  input logic              trail_i,
  input logic              word_i,
  input logic [DATA_W-1:0] count_o
);
  localparam int CW = $clog2(DATA_W + 1);

  int                c;
  logic [HALF_W-1:0] lo;
  logic [DATA_W-1:0] sh_full;
  logic [HALF_W-1:0] sh_half;

  always_comb begin
    c       = int'(count_o[CW-1:0]);
    lo      = operand_i[HALF_W-1:0];
    sh_full = '0;
    sh_half = '0;

    a_r7_upper_clear: assert (count_o[DATA_W-1:CW] == '0)
      else $error("count upper bits not zero");
    a_r7_in_range: assert (word_i ? (c <= HALF_W) : (c <= DATA_W))
      else $error("count out of range");

    if (!word_i && operand_i == '0) begin
      a_r5_zero_double: assert (c == DATA_W) else $error("zero doubleword count");
    end
    if (word_i && lo == '0) begin
      a_r6_zero_word: assert (c == HALF_W) else $error("zero word count");
    end

    if (!trail_i && !word_i && c < DATA_W) begin
      sh_full = operand_i >> (DATA_W - 1 - c);
      a_r1_lead_double: assert (sh_full[0] && (c == 0 || (operand_i >> (DATA_W - c)) == '0))
        else $error("leading doubleword count");
    end
    if (!trail_i && word_i && c < HALF_W) begin
      sh_half = lo >> (HALF_W - 1 - c);
      a_r2_lead_word: assert (sh_half[0] && (c == 0 || (lo >> (HALF_W - c)) == '0))
        else $error("leading word count");
    end
    if (trail_i && !word_i && c < DATA_W) begin
      sh_full = operand_i >> c;
      a_r3_trail_double: assert (sh_full[0] && (c == 0 || (operand_i << (DATA_W - c)) == '0))
        else $error("trailing doubleword count");
    end
    if (trail_i && word_i && c < HALF_W) begin
      sh_half = lo >> c;
      a_r4_trail_word: assert (sh_half[0] && (c == 0 || (lo << (HALF_W - c)) == '0))
        else $error("trailing word count");
    end
  end

endmodule

bind zero_run_counter zrc_checker #(.DATA_W(DATA_W), .HALF_W(HALF_W)) chk_i (
  .operand_i (operand_i),
  .trail_i   (trail_i),
  .word_i    (word_i),
  .count_o   (count_o)
);

// File: tb/zero_run_counter_tb_top.sv
module zero_run_counter_tb_top;

  logic        clk = 1'b0;
  logic [63:0] operand = '0;
  logic        trail = 1'b0;
  logic        word = 1'b0;
  logic [63:0] count;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  zero_run_counter dut_i (
    .operand_i (operand),
    .trail_i   (trail),
    .word_i    (word),
    .count_o   (count)
  );

  function automatic int ref_cnt(logic [63:0] x, logic t, logic w);
    int n = w ? 32 : 64;
    int r = n;
    if (!t) begin
      for (int i = n - 1; i >= 0; i--) if (x[i]) begin r = n - 1 - i; break; end
    end else begin
      for (int i = 0; i < n; i++) if (x[i]) begin r = i; break; end
    end
    return r;
  endfunction

  function automatic string tag_of(logic [63:0] x, logic t, logic w);
    if (w && x[31:0] == '0) return "R6";
    if (!w && x == '0)      return "R5";
    case ({t, w})
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic compare(string tag);
    logic [63:0] exp = 64'(ref_cnt(operand, trail, word));
    n_vec++;
    if (count !== exp) begin
      n_fail++;
      $display("FAIL %s (R7 width) op=%h trail=%0b word=%0b got=%h exp=%h",
               tag, operand, trail, word, count, exp);
    end
  endtask

  task automatic apply(logic [63:0] x, logic t, logic w);
    @(posedge clk);
    operand = x; trail = t; word = w;
    @(negedge clk);
    compare(tag_of(x, t, w));
  endtask

  initial begin
    logic [63:0] r;
    int k;
    void'($urandom(32'h5eed_0c0f));

    // Initial state: zero operand in leading doubleword mode gives 64 (R5).
    @(negedge clk);
    compare("R5");

    // R5 and R6: zero field in every mode; garbage above the word in word mode.
    for (int m = 0; m < 4; m++) apply('0, m[1], m[0]);
    apply(64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1);
    apply(64'h8000_0001_0000_0000, 1'b1, 1'b1);

    // R1..R4: single set bit walked over every position in every mode.
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 64; p++) apply(64'd1 << p, m[1], m[0]);

    // R2, R4: upper word full of ones must not disturb the word count.
    apply(64'hFFFF_FFFF_0000_0100, 1'b0, 1'b1);
    apply(64'hFFFF_FFFF_0000_0100, 1'b1, 1'b1);

    // R8: mid-cycle input change, sampled 1 ns later with no clock edge between.
    @(posedge clk);
    #1 operand = 64'h0000_0000_0001_0000; trail = 1'b1; word = 1'b0;
    #1 compare("R8,R3");
    #1 trail = 1'b0;
    #1 compare("R8,R1");

    // Random values with a one-hot marker; bits on the far side of it are random.
    for (int j = 0; j < 600; j++) begin
      r = {$urandom, $urandom};
      k = int'($urandom_range(0, 63));
      for (int m = 0; m < 4; m++) begin
        if (m[1]) apply((r & ~((64'd1 << k) - 64'd1) & ~(64'd1 << k)) | (64'd1 << k) | (r & 64'hFFFF_FFFF_0000_0000), m[1], m[0]);
        else      apply((r & ((64'd1 << k) - 64'd1)) | (64'd1 << k) | (r & 64'hFFFF_FFFF_0000_0000), m[1], m[0]);
      end
    end

    // Plain random operands, all modes (R7 range on every one).
    for (int j = 0; j < 400; j++) begin
      r = {$urandom, $urandom} >> $urandom_range(0, 63);
      apply(r, 1'($urandom), 1'($urandom));
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired: got=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule